// File: doc/BRIEF.md
# Saturating Element Width Converter

This block converts one integer element from one element width to another. When narrowing, it takes a 16, 32 or 64-bit source and reduces it to 8, 16 or 32 bits. The reduction keeps the low bits unchanged, or it clamps the value to the destination range under signed or unsigned rules. When widening, it extends a narrow element with its sign bit or with zeros. Control inputs select the width pair, the direction, the signedness and whether clamping is active. In a vector datapath, the caller typically changes only these per-instruction controls and issues one element per cycle.

The result is registered and appears one cycle after the valid strobe. The block raises a flag when clamping altered the value. It raises a separate error flag when the requested width pair does not fit the direction; in that case the source is passed through unchanged.

Top module: `elem_width_conv`

## Requirements
- R1: After reset, `out_valid`, `out_data`, `out_sat` and `out_err` are all zero. `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was sampled high, and is low otherwise.
- R2: Width codes are 0=8, 1=16, 2=32 and 3=64 bits. The source element is the low W bits of `src_data`, where W is given by `src_wcode`; higher bits are ignored. When narrowing with `sat_en`=0, the low M bits of the element are kept, where M is given by `dst_wcode`. Bits above M are filled with copies of bit M-1 when `is_signed`=1, and with zeros when `is_signed`=0.
- R3: When narrowing with `sat_en`=1 and `is_signed`=1, the element is read as a two's complement number and limited to the range -2^(M-1) to 2^(M-1)-1. The result is then sign-filled to 64 bits.
- R4: When narrowing with `sat_en`=1 and `is_signed`=0, the element is read as an unsigned number, so a set top bit counts as large. The value is limited to at most 2^M-1, and the result is zero-filled to 64 bits.
- R5: `out_sat` is 1 only when clamping changed the value. It is 0 for an in-range value, including one exactly at a limit, for truncation, for widening, and for an illegal request.
- R6: Widening (`widen`=1) extends the W-bit element to 64 bits, using its sign when `is_signed`=1 and zeros when `is_signed`=0. `sat_en` has no effect on a widening request.
- R7: A request is illegal when the destination code is not smaller than the source code while narrowing, or not larger while widening. For an illegal request, `out_data` equals the full 64-bit `src_data`, `out_err`=1 and `out_sat`=0.
- R8: While `in_valid` is low, `out_data`, `out_sat` and `out_err` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_data | input | 64 | Source element in the low bits |
| src_wcode | input | 2 | Source width code |
| dst_wcode | input | 2 | Destination width code |
| widen | input | 1 | 1 = widen, 0 = narrow |
| is_signed | input | 1 | Signed interpretation and sign fill |
| sat_en | input | 1 | Clamp instead of truncate when narrowing |
| out_data | output | 64 | Converted element |
| out_sat | output | 1 | Clamping altered the value |
| out_err | output | 1 | Illegal width pair |
| out_valid | output | 1 | Result valid |

## Verification
The output register is loaded in the same cycle as the request, so any fault in the limit comparison, the fill mask or the legality decision shows up in the result one cycle after that request. A wrong limit or comparison appears either as a clamped value one step off or as a flag that disagrees with the data. These faults surface most clearly at the exact range edges, so the bench tests those edges directly. A fault in the hold path appears as a result that changes in a cycle without a strobe.

// File: rtl/elem_width_conv.sv
module elem_width_conv #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] src_data,
  input  logic [1:0]    src_wcode,
  input  logic [1:0]    dst_wcode,
  input  logic          widen,
  input  logic          is_signed,
  input  logic          sat_en,
  output logic [DW-1:0] out_data,
  output logic          out_sat,
  output logic          out_err,
  output logic          out_valid
);

  function automatic logic [DW-1:0] wmask(input logic [1:0] c);
    case (c)
      2'd0:    wmask = DW'({8{1'b1}});
      2'd1:    wmask = DW'({16{1'b1}});
      2'd2:    wmask = DW'({32{1'b1}});
      default: wmask = {DW{1'b1}};
    endcase
  endfunction

  function automatic logic topbit(input logic [DW-1:0] v, input logic [1:0] c);
    case (c)
      2'd0:    topbit = v[7];
      2'd1:    topbit = v[15];
      2'd2:    topbit = v[31];
      default: topbit = v[DW-1];
    endcase
  endfunction

  function automatic logic [DW-1:0] fill(input logic [DW-1:0] v, input logic [1:0] c,
                                         input logic sgn);
    logic [DW-1:0] m;
    m = wmask(c);
    fill = (sgn && topbit(v, c)) ? ((v & m) | ~m) : (v & m);
  endfunction

  logic          legal;
  logic [DW-1:0] elem;
  logic [DW-1:0] hi_lim, lo_lim;
  logic          over, under;
  logic [DW-1:0] clamped;
  logic [DW-1:0] narrow_res;
  logic [DW-1:0] nxt_data;
  logic          nxt_sat;

  assign legal  = widen ? (dst_wcode > src_wcode) : (dst_wcode < src_wcode);
  assign elem   = fill(src_data, src_wcode, is_signed);
  assign hi_lim = is_signed ? (wmask(dst_wcode) >> 1) : wmask(dst_wcode);
  assign lo_lim = is_signed ? ~(wmask(dst_wcode) >> 1) : '0;

  always_comb begin
    if (is_signed) begin
      over  = $signed(elem) > $signed(hi_lim);
      under = $signed(elem) < $signed(lo_lim);
    end else begin
      over  = elem > hi_lim;
      under = 1'b0;
    end
  end

  assign clamped    = !sat_en ? elem : over ? hi_lim : under ? lo_lim : elem;
  assign narrow_res = fill(clamped, dst_wcode, is_signed);

  always_comb begin
    if (!legal) begin
      nxt_data = src_data;
      nxt_sat  = 1'b0;
    end else if (widen) begin
      nxt_data = elem;
      nxt_sat  = 1'b0;
    end else begin
      nxt_data = narrow_res;
      nxt_sat  = sat_en && (over || under);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_sat   <= 1'b0;
      out_err   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_sat  <= nxt_sat;
        out_err  <= !legal;
      end
    end
  end

endmodule

// File: rtl/elem_width_conv_chk.sv
module elem_width_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] src_data,
  input logic [1:0]  src_wcode,
  input logic [1:0]  dst_wcode,
  input logic        widen,
  input logic        is_signed,
  input logic        sat_en,
  input logic [63:0] out_data,
  input logic        out_sat,
  input logic        out_err,
  input logic        out_valid
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (widen ? (dst_wcode <= src_wcode) : (dst_wcode >= src_wcode))
    |=> out_err && !out_sat && out_data == $past(src_data));

  // R5
  sat_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (widen || !sat_en) |=> !out_sat);

  // R6
  widen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && widen && !is_signed && src_wcode == 2'd0 && dst_wcode != 2'd0
    |=> out_data[63:8] == 56'd0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_sat) && $stable(out_err));

endmodule

bind elem_width_conv elem_width_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
  .src_wcode(src_wcode), .dst_wcode(dst_wcode), .widen(widen),
  .is_signed(is_signed), .sat_en(sat_en), .out_data(out_data),
  .out_sat(out_sat), .out_err(out_err), .out_valid(out_valid)
);

// File: tb/elem_width_conv_tb.sv
module elem_width_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_data = '0;
  logic [1:0]  src_wcode = '0;
  logic [1:0]  dst_wcode = '0;
  logic        widen = 1'b0;
  logic        is_signed = 1'b0;
  logic        sat_en = 1'b0;
  logic [63:0] out_data;
  logic        out_sat, out_err, out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  elem_width_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_data(src_data),
    .src_wcode(src_wcode), .dst_wcode(dst_wcode), .widen(widen),
    .is_signed(is_signed), .sat_en(sat_en), .out_data(out_data),
    .out_sat(out_sat), .out_err(out_err), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [63:0] d, input logic [1:0] s, input logic [1:0] t,
                    input logic w, input logic sg, input logic st);
    src_data = d; src_wcode = s; dst_wcode = t;
    widen = w; is_signed = sg; sat_en = st; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [63:0] d, input logic sat,
                            input logic err);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " data"}, out_data, d);
    check({req, " sat"}, 64'(out_sat), 64'(sat));
    check({req, " err"}, 64'(out_err), 64'(err));
  endtask

  task automatic t_reset;
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset data", out_data, 64'd0);
    check("R1 reset sat", 64'(out_sat), 64'd0);
    check("R1 reset err", 64'(out_err), 64'd0);
  endtask

  task automatic t_trunc;
    op(64'h1234_5678_9ABC_DEF0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
    expect_res("R2 trunc 64-8 zero", 64'h0000_0000_0000_00F0, 1'b0, 1'b0);
    op(64'h1234_5678_9ABC_DEF0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0);
    expect_res("R2 trunc 64-8 sign", 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b0);
    op(64'hAAAA_BBBB_CCCC_7FFF, 2'd3, 2'd1, 1'b0, 1'b1, 1'b0);
    expect_res("R2 trunc 64-16 pos", 64'h0000_0000_0000_7FFF, 1'b0, 1'b0);
  endtask

  task automatic t_ssat;
    op(64'h0000_0000_0000_0200, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1);
    expect_res("R3 ssat high", 64'h0000_0000_0000_007F, 1'b1, 1'b0);
    op(64'h0000_0000_FFFF_FF00, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1);
    expect_res("R3 ssat low", 64'hFFFF_FFFF_FFFF_FF80, 1'b1, 1'b0);
    op(64'h0000_0000_FFFF_FF80, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1);
    expect_res("R5 ssat at min", 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 1'b0);
    op(64'hDEAD_BEEF_0000_0005, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1);
    expect_res("R2 upper ignored", 64'h0000_0000_0000_0005, 1'b0, 1'b0);
    op(64'h8000_0000_0000_0000, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1);
    expect_res("R3 ssat 64-32", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_usat;
    op(64'h0000_0000_0000_0100, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    expect_res("R4 usat over", 64'h0000_0000_0000_00FF, 1'b1, 1'b0);
    op(64'h0000_0000_0000_00FF, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    expect_res("R5 usat at max", 64'h0000_0000_0000_00FF, 1'b0, 1'b0);
    op(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd2, 1'b0, 1'b0, 1'b1);
    expect_res("R4 usat topbit", 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_widen;
    op(64'h1234_5678_9ABC_DE80, 2'd0, 2'd3, 1'b1, 1'b1, 1'b1);
    expect_res("R6 widen sign", 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 1'b0);
    op(64'h1234_5678_9ABC_DE80, 2'd0, 2'd3, 1'b1, 1'b0, 1'b0);
    expect_res("R6 widen zero", 64'h0000_0000_0000_0080, 1'b0, 1'b0);
    op(64'hAAAA_BBBB_CCCC_8001, 2'd1, 2'd2, 1'b1, 1'b1, 1'b0);
    expect_res("R6 widen 16-32", 64'hFFFF_FFFF_FFFF_8001, 1'b0, 1'b0);
  endtask

  task automatic t_illegal;
    op(64'h1111_2222_3333_4444, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    expect_res("R7 narrow same", 64'h1111_2222_3333_4444, 1'b0, 1'b1);
    op(64'h5555_6666_7777_8888, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0);
    expect_res("R7 widen down", 64'h5555_6666_7777_8888, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    op(64'h0000_0000_0000_0300, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
    expect_res("R8 setup", 64'h0000_0000_0000_00FF, 1'b1, 1'b0);
    src_data = 64'h0123_4567_89AB_CDEF; src_wcode = 2'd0; dst_wcode = 2'd0;
    @(posedge clk); #1;
    check("R1 idle valid", 64'(out_valid), 64'd0);
    check("R8 hold data", out_data, 64'h0000_0000_0000_00FF);
    check("R8 hold sat", 64'(out_sat), 64'd1);
    check("R8 hold err", 64'(out_err), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_trunc();
    t_ssat();
    t_usat();
    t_widen();
    t_illegal();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule